// File: doc/BRIEF.md
# Byte Serial Peripheral Interface Controller

This block moves one byte at a time over a four-wire SPI link and can act either as the link master or as a slave. Software reaches it through a small register port with three addresses. The data address starts a transfer and returns the last byte received. The control address sets the mode, the clock polarity and phase, and the master bit rate. The status address reports a finished transfer, an overrun and a master mode fault. A single interrupt line combines the three status conditions, and an interrupt enable bit masks it.

In master mode the block produces SCK from the system clock through a power-of-two divider. It drives MOSI and samples MISO. In slave mode it takes SCK, MOSI and the active-low select from the pins through synchronizers and drives MISO while it is selected. If the select pin goes low while the block is master, some other device is driving the bus. The block then leaves master mode and turns itself off without software action, and it records the event.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, the interrupt is low and every pin output enable is low.
- R2: Control bit 6 enables the peripheral and drives `spi_pin_en`. While it is 0, `sck_oe`, `mosi_oe` and `miso_oe` stay low. While it is 1 with bit 4 set, `sck_oe` and `mosi_oe` are high.
- R3: The control register fields are: bit 7 interrupt enable, bit 6 enable, bit 5 divider bypass, bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate select. A written value reads back unchanged.
- R4: In master mode each SCK half period lasts 2^(rate+1) system clocks when bit 5 is 1, and twice that when bit 5 is 0. Between transfers SCK rests at the level of bit 3.
- R5: A transfer is 8 bits, MSB first, on 16 SCK edges. With phase 0 both sides sample on the 1st, 3rd and later odd-numbered edges. With phase 1 they sample on the even-numbered edges. The master sends the written byte on MOSI and collects the byte received on MISO.
- R6: A write to the data address (address 0) while enabled in master mode and idle starts a transfer. A write during a transfer is ignored: the byte on the wire stays the same and no further transfer follows.
- R7: In slave mode with `ss_n` low, the block shifts in from MOSI on edges of `sck_in` and drives MISO with `miso_oe` high. With `ss_n` high, `miso_oe` is low.
- R8: At the end of a byte, status bit 0 (done) is set and the received byte reads at the data address.
- R9: If a byte ends while status bit 0 is still set, status bit 1 (overrun) is set and the earlier received byte is kept.
- R10: If `ss_n` is low while enabled in master mode, control bits 6 and 4 clear and status bit 2 (mode fault) is set.
- R11: `irq` is high exactly when control bit 7 is set and any of status bits 0, 1 or 2 is set.
- R12: A status read followed by any data access clears status bits 0 and 1 but not bit 2. A status read followed by a control write clears bit 2.
- R13: When the clear of R12 and a byte completion fall in the same cycle, the clear acts first. Bit 0 ends set, bit 1 ends clear, and the new byte is readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Combined interrupt |
| spi_pin_en | output | 1 | Pins given to the serial function |
| sck_in | input | 1 | Serial clock from the pin (slave) |
| sck_out | output | 1 | Serial clock to the pin (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_in | input | 1 | Master-out line from the pin (slave) |
| mosi_out | output | 1 | Master-out line to the pin |
| mosi_oe | output | 1 | Master-out drive enable |
| miso_in | input | 1 | Master-in line from the pin (master) |
| miso_out | output | 1 | Master-in line to the pin (slave) |
| miso_oe | output | 1 | Master-in drive enable |
| ss_n | input | 1 | Active-low slave select / fault sense |

## Verification
The flag-clearing access and the end of a byte can arrive in the same clock. This case decides whether the flags report a completion or an overrun. The bench leaves the done flag set and then starts a transfer at the fastest rate. From the register timing it computes the exact cycle in which the done flag will update. It reads the status during the transfer and places the clearing data read in that cycle. It expects done set, overrun clear and the new byte in the data register. A second meeting, a control write in the same cycle as a mode fault, goes to the hardware clear: R10 and its assertion cover it.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int RATE_W = 2;
  localparam int HALF_W = (1 << RATE_W) + 2;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef struct packed {
    logic              ie;
    logic              en;
    logic              div_off;
    logic              mstr;
    logic              cpol;
    logic              cpha;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  // system clocks per SCK half period
  function automatic logic [HALF_W-1:0] half_cycles(input logic [RATE_W-1:0] rate,
                                                    input logic div_off);
    logic [HALF_W-1:0] base;
    base = HALF_W'(2) << rate;
    return div_off ? base : (base << 1);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_pkg::*;
#(
  parameter int EDGES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [HALF_W-1:0] half,
  input  logic              cpol,
  output logic              sck,
  output logic              edge_ev,
  output logic              busy
);
  localparam int EW = $clog2(EDGES);
  logic [HALF_W-1:0] cnt;
  logic [EW-1:0]     ecnt;

  assign edge_ev = busy && (cnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      ecnt <= '0;
      sck  <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
      sck  <= cpol;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      ecnt <= '0;
      sck  <= cpol;
    end else if (busy) begin
      if (edge_ev) begin
        cnt  <= '0;
        sck  <= ~sck;
        ecnt <= ecnt + 1'b1;
        if (ecnt == EW'(EDGES - 1)) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      sck <= cpol;
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              restart,
  input  logic              edge_ev,
  input  logic              in_bit,
  input  logic              cpha,
  output logic              out_bit,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done,
  output logic              idx_nz
);
  localparam int EDGES = 2 * DATA_W;
  localparam int IW    = $clog2(EDGES);

  logic [DATA_W-1:0] tx_sr;
  logic [IW-1:0]     idx;
  logic              sample_edge, hold_first;

  assign sample_edge = (idx[0] == cpha);
  assign hold_first  = cpha && (idx == '0);
  assign out_bit     = tx_sr[DATA_W-1];
  assign idx_nz      = (idx != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_byte <= '0;
      idx     <= '0;
      done    <= 1'b0;
    end else begin
      done <= edge_ev && !restart && (idx == IW'(EDGES - 1));
      if (load) tx_sr <= load_data;
      else if (edge_ev && !restart && !sample_edge && !hold_first)
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      if (restart) idx <= '0;
      else if (edge_ev) begin
        idx <= idx + 1'b1;
        if (sample_edge) rx_byte <= {rx_byte[DATA_W-2:0], in_bit};
      end
    end
  end
endmodule

// File: rtl/spi_status.sv
module spi_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_in,
  input  logic              clr_data,
  input  logic              clr_fault,
  input  logic              fault_ev,
  input  logic              ie,
  output logic              tcf,
  output logic              ovr,
  output logic              modf,
  output logic [DATA_W-1:0] rx_buf,
  output logic              irq
);
  logic tcf_kept;
  assign tcf_kept = tcf && !clr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcf    <= 1'b0;
      ovr    <= 1'b0;
      modf   <= 1'b0;
      rx_buf <= '0;
    end else begin
      tcf <= tcf_kept || done;
      ovr <= (ovr && !clr_data) || (done && tcf_kept);
      if (done && !tcf_kept) rx_buf <= rx_in;
      modf <= fault_ev || (modf && !clr_fault);
    end
  end

  assign irq = ie && (tcf || ovr || modf);
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              spi_pin_en,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic              ss_n
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic              sck_s, sck_p, mosi_s, ss_s;
  logic              wr_data, rd_data, wr_ctrl, rd_stat, data_acc;
  logic              seen_q, clr_data, clr_fault;
  logic              master_mode, fault_ev, m_start, m_abort;
  logic              m_sck, m_edge, m_busy, s_edge;
  logic              sh_edge, sh_restart, sh_load, sh_in, sh_out, idx_nz, done_q;
  logic [DATA_W-1:0] rx_byte, rx_buf;
  logic              tcf, ovr, modf;
  logic [HALF_W-1:0] half;

  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck  (.clk(clk), .rst_n(rst_n), .d(sck_in),  .q(sck_s));
  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (.clk(clk), .rst_n(rst_n), .d(mosi_in), .q(mosi_s));
  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss   (.clk(clk), .rst_n(rst_n), .d(ss_n),    .q(ss_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_p <= 1'b0;
    else        sck_p <= sck_s;
  end

  // register port decode
  assign wr_data  = bus_wr && (bus_addr == A_DATA);
  assign rd_data  = bus_rd && (bus_addr == A_DATA);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign rd_stat  = bus_rd && (bus_addr == A_STAT);
  assign data_acc = wr_data || rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     seen_q <= 1'b0;
    else if (data_acc || wr_ctrl)   seen_q <= 1'b0;
    else if (rd_stat)               seen_q <= 1'b1;
  end
  assign clr_data  = seen_q && data_acc;
  assign clr_fault = seen_q && wr_ctrl;

  // mode control and fault
  assign master_mode = ctrl_q.en && ctrl_q.mstr;
  assign fault_ev    = master_mode && !ss_s;
  assign m_abort     = fault_ev || !master_mode;
  assign m_start     = wr_data && master_mode && !m_busy && !fault_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (fault_ev) begin
        ctrl_q.en   <= 1'b0;
        ctrl_q.mstr <= 1'b0;
      end
    end
  end

  assign half = half_cycles(ctrl_q.rate, ctrl_q.div_off);

  spi_clkgen #(.EDGES(EDGES)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start(m_start), .abort(m_abort),
    .half(half), .cpol(ctrl_q.cpol),
    .sck(m_sck), .edge_ev(m_edge), .busy(m_busy)
  );

  assign s_edge     = ctrl_q.en && !ctrl_q.mstr && !ss_s && (sck_s ^ sck_p);
  assign sh_edge    = ctrl_q.mstr ? m_edge : s_edge;
  assign sh_restart = m_start || fault_ev || !ctrl_q.en || (!ctrl_q.mstr && ss_s);
  assign sh_load    = wr_data && !m_busy && !idx_nz;
  assign sh_in      = ctrl_q.mstr ? miso_in : mosi_s;

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_data(bus_wdata),
    .restart(sh_restart), .edge_ev(sh_edge), .in_bit(sh_in), .cpha(ctrl_q.cpha),
    .out_bit(sh_out), .rx_byte(rx_byte), .done(done_q), .idx_nz(idx_nz)
  );

  spi_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .done(done_q), .rx_in(rx_byte),
    .clr_data(clr_data), .clr_fault(clr_fault), .fault_ev(fault_ev), .ie(ctrl_q.ie),
    .tcf(tcf), .ovr(ovr), .modf(modf), .rx_buf(rx_buf), .irq(irq)
  );

  // pins
  assign spi_pin_en = ctrl_q.en;
  assign sck_oe     = master_mode;
  assign sck_out    = master_mode ? m_sck : ctrl_q.cpol;
  assign mosi_oe    = master_mode;
  assign mosi_out   = sh_out;
  assign miso_oe    = ctrl_q.en && !ctrl_q.mstr && !ss_s;
  assign miso_out   = sh_out;

  always_comb begin
    unique case (bus_addr)
      A_DATA:  bus_rdata = rx_buf;
      A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      A_STAT:  bus_rdata = DATA_W'({modf, ovr, tcf});
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ctrl_v,
  input logic              fault_ev,
  input logic              done_q,
  input logic              tcf,
  input logic              ovr,
  input logic              modf,
  input logic [DATA_W-1:0] rx_buf,
  input logic              clr_data,
  input logic              m_busy,
  input logic              m_sck,
  input logic              irq,
  input logic              sck_oe,
  input logic              mosi_oe,
  input logic              miso_oe
);
  assert_fault_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> (!ctrl_v[6] && !ctrl_v[4] && modf));

  assert_ovr_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && tcf && !clr_data) |=> (ovr && $stable(rx_buf)));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_busy && $past(!m_busy) && $stable(ctrl_v[3])) |-> (m_sck == ctrl_v[3]));

  assert_pins_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_v[6] |-> !(sck_oe || mosi_oe || miso_oe));

  assert_irq_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_v[7] |-> !irq);

  assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (tcf && !done_q));
endmodule

bind spi_ctrl spi_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_v(8'(ctrl_q)), .fault_ev(fault_ev), .done_q(done_q),
  .tcf(tcf), .ovr(ovr), .modf(modf), .rx_buf(rx_buf), .clr_data(clr_data),
  .m_busy(m_busy), .m_sck(m_sck), .irq(irq),
  .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe)
);

// File: tb/tb_spi_ctrl.sv
module tb_spi_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, spi_pin_en;
  logic       sck_in = 1'b0, sck_out, sck_oe;
  logic       mosi_in = 1'b0, mosi_out, mosi_oe;
  logic       miso_in, miso_out, miso_oe;
  logic       ss_n = 1'b1;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench-side serial peer for master transfers
  bit       mon_on = 0, mon_prev = 0;
  int       mon_edges = 0, mon_samp = 0, mon_gap = 0, mon_gap_bad = 0;
  int       mon_half = 2, cur_cpha = 0;
  logic [7:0] mon_pat = 8'd0, mon_got = 8'd0;

  always #10 clk = ~clk;

  spi_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .spi_pin_en(spi_pin_en),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe), .ss_n(ss_n)
  );

  assign miso_in = (mon_samp < 8) ? mon_pat[3'(7 - mon_samp)] : 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      mon_gap++;
      if (sck_out != mon_prev) begin
        if (mon_edges > 0 && mon_gap != mon_half) mon_gap_bad++;
        mon_gap = 0;
        if ((mon_edges % 2) == cur_cpha) begin
          mon_got = {mon_got[6:0], mosi_out};
          mon_samp++;
        end
        mon_edges++;
        mon_prev = sck_out;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  function automatic int half_of(input logic [7:0] c);
    return (1 << (c[1:0] + 1)) * (c[5] ? 1 : 2);
  endfunction

  task automatic arm_monitor(input logic [7:0] c, input logic [7:0] pat);
    cur_cpha = int'(c[2]); mon_half = half_of(c); mon_pat = pat;
    mon_got = 0; mon_edges = 0; mon_samp = 0; mon_gap = 0; mon_gap_bad = 0;
    mon_prev = sck_out; mon_on = 1;
  endtask

  task automatic run_master(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] pat);
    bus_write(2'd1, c);
    repeat (2) @(negedge clk);
    arm_monitor(c, pat);
    bus_write(2'd0, tx);
    repeat (16 * half_of(c) + 4) @(negedge clk);
    mon_on = 0;
  endtask

  task automatic clear_done();
    logic [7:0] d;
    bus_read(2'd2, d);
    bus_read(2'd0, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, c, tx, pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd1, d); chk("R1 ctrl", d, 8'h00);
    bus_read(2'd2, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 oe", {sck_oe, mosi_oe, miso_oe}, 0);
    chk("R2 pin_en off", spi_pin_en, 0);

    // R3 readback, R2 disabled pins
    bus_write(2'd1, 8'hA7);
    bus_read(2'd1, d); chk("R3 readback", d, 8'hA7);
    chk("R2 disabled oe", {sck_oe, mosi_oe, miso_oe, spi_pin_en}, 0);

    // R4 R5 R8 R11 R12 sweep over every master configuration
    for (int k = 0; k < 32; k++) begin
      c   = {1'b1, 1'b1, k[4], 1'b1, k[3], k[2], k[1:0]};
      tx  = 8'hA5 ^ 8'(k * 37);
      pat = 8'h3C ^ 8'(k * 71);
      run_master(c, tx, pat);
      chk("R2 master oe", {spi_pin_en, sck_oe, mosi_oe}, 3'b111);
      chk("R5 mosi stream", mon_got, tx);
      chk("R4 edge count", mon_edges, 16);
      chk("R4 half period", mon_gap_bad, 0);
      chk("R4 idle level", sck_out, c[3]);
      chk("R11 irq on done", irq, 1);
      bus_read(2'd2, d); chk("R8 done flag", d, 8'h01);
      bus_read(2'd0, d); chk("R5 received byte", d, pat);
      bus_read(2'd2, d); chk("R12 flags cleared", d, 8'h00);
    end

    // R6 write during a transfer is ignored
    c = 8'hF0;
    bus_write(2'd1, c);
    repeat (2) @(negedge clk);
    arm_monitor(c, 8'h5E);
    bus_write(2'd0, 8'h3C);
    repeat (6) @(negedge clk);
    bus_write(2'd0, 8'hFF);
    repeat (90) @(negedge clk);
    mon_on = 0;
    chk("R6 byte unchanged", mon_got, 8'h3C);
    chk("R6 no second transfer", mon_edges, 16);
    bus_read(2'd2, d); chk("R6 one done", d, 8'h01);
    clear_done();

    // R9 overrun keeps earlier byte
    run_master(8'hF0, 8'h01, 8'h11);
    run_master(8'hF0, 8'h02, 8'h22);
    bus_read(2'd2, d); chk("R9 overrun flag", d, 8'h03);
    bus_read(2'd0, d); chk("R9 earlier byte kept", d, 8'h11);
    bus_read(2'd2, d); chk("R12 overrun cleared", d, 8'h00);

    // R13 clear and completion in one cycle (half period 2)
    run_master(8'hF0, 8'h81, 8'h42);
    arm_monitor(8'hF0, 8'h99);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h18; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd2; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    repeat (31) @(negedge clk);
    bus_addr = 2'd0; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
    chk("R13 new byte", d, 8'h99);
    repeat (2) @(negedge clk);
    mon_on = 0;
    bus_read(2'd2, d); chk("R13 done set no overrun", d, 8'h01);
    clear_done();

    // R11 masked interrupt
    run_master(8'h70, 8'h55, 8'hAA);
    chk("R11 masked irq", irq, 0);
    bus_read(2'd2, d); chk("R11 flag still set", d, 8'h01);
    clear_done();

    // R10 mode fault, R12 fault clearing
    bus_write(2'd1, 8'hD0);
    ss_n = 1'b0;
    repeat (5) @(negedge clk);
    bus_read(2'd1, d); chk("R10 ctrl bits cleared", d, 8'h80);
    chk("R10 sck released", sck_oe, 0);
    chk("R11 irq on fault", irq, 1);
    bus_read(2'd2, d); chk("R10 fault flag", d, 8'h04);
    bus_read(2'd0, d);
    bus_read(2'd2, d); chk("R12 data access keeps fault", d, 8'h04);
    bus_write(2'd1, 8'h00);
    bus_read(2'd2, d); chk("R12 fault cleared", d, 8'h00);
    chk("R11 irq low", irq, 0);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 slave transfers, both phases
    for (int ph = 0; ph < 2; ph++) begin
      logic [7:0] stx, smo, got;
      stx = ph ? 8'h6D : 8'hC3;
      smo = ph ? 8'hB4 : 8'h5A;
      got = 8'h00;
      bus_write(2'd1, 8'h40 | 8'(ph << 2));
      bus_write(2'd0, stx);
      chk("R7 miso off unselected", miso_oe, 0);
      ss_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R7 miso driven", miso_oe, 1);
      for (int i = 0; i < 8; i++) begin
        if (ph == 0) begin
          mosi_in = smo[7 - i];
          repeat (8) @(negedge clk);
          got = {got[6:0], miso_out};
          sck_in = 1'b1;
          repeat (8) @(negedge clk);
          sck_in = 1'b0;
        end else begin
          sck_in = 1'b1;
          repeat (4) @(negedge clk);
          mosi_in = smo[7 - i];
          got = {got[6:0], miso_out};
          repeat (4) @(negedge clk);
          sck_in = 1'b0;
          repeat (8) @(negedge clk);
        end
      end
      repeat (8) @(negedge clk);
      ss_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7 miso stream", got, stx);
      bus_read(2'd2, d); chk("R8 slave done", d, 8'h01);
      bus_read(2'd0, d); chk("R7 slave received", d, smo);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule